// File: doc/BRIEF.md
# Gated Down-Counter Timer with Capture

This block is a down-counting timer whose counter clock is a prescaled, synchronized external clock input. It runs in a combined capture and compare mode. The live counter loads a preload value, then counts down to zero and reloads. Each time it takes the compare value it sets a sticky compare flag and applies a selectable action to the timer output pin.

Software sees the count through a readable count register. This register follows the live counter one system clock behind. A rising edge on the synchronized, active-low gate pin, when gate enable is set, sets a gate flag. While that flag is set, the count register stays frozen at the value it held when the edge was seen, and the live counter keeps running. Software clears the flag by writing a one to it, and the register then tracks the counter again. Control and status use a plain register port: writes take effect at the clock edge, and reads are combinational. The block has no streaming data path, so it has no valid/ready handshake.

Register map (3-bit address): 0 control, 1 status, 2 preload, 3 compare, 4 count (read only). Any other address reads zero.

Top module: `gated_capture_timer`

## Requirements
- R1: The timer can run only when the 3-bit mode field (control bits 2:0) is 000. Any other mode keeps it idle: the running bit reads 0 and the live count is held at 0.
- R2: The timer runs only when both the prescaler enable (control bit 3) and the software-reset bit (control bit 4) are 1. When it is not running, the live count is 0, both status flags are 0, and the output pin drives the initial level (control bit 8).
- R3: The running status bit (status bit 0) reads 1 from the cycle after the enable conditions hold, and reads 0 from the cycle after they stop holding.
- R4: The first counter tick after enabling loads the preload register. Each later tick decrements the count, except that a tick at count 0 reloads the preload value.
- R5: A counter tick occurs on every 2^P-th falling edge of the external clock input, where P is control bits 11:9. The input passes a two-flop synchronizer, so the live count changes on the third rising system-clock edge after the input falls, when that fall completes a prescale period.
- R6: While the gate flag is 0, the count register (address 4) takes the live count at each rising edge, so it lags the live counter by one cycle.
- R7: When gate enable (control bit 5) is 1 and the timer runs, a rising edge of the synchronized gate pin sets the gate flag (status bit 1). This freezes the count register and does not affect counting. When gate enable is 0, the gate pin has no effect.
- R8: The gate flag and the compare flag (status bit 2) are cleared by writing 1 to their bit at address 1. Writing 0 has no effect, and a set in the same cycle wins over a clear.
- R9: On a tick whose new count equals the compare register, the compare flag sets and the output action (control bits 7:6) applies: 00 hold, 01 toggle, 10 drive low, 11 drive high. No other event changes the output while the timer is running.
- R10: After reset every register, flag and the output pin are 0. Registers written at addresses 0, 2 and 3 read back at the next cycle, and the control register is 12 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| ext_clk_in | input | 1 | Asynchronous external counter clock |
| gate_n_in | input | 1 | Asynchronous active-low gate pin |
| tmr_out | output | 1 | Timer output pin |

## Verification
A falling edge of the external clock input changes the live count on the third rising edge after the input falls. The count register shows the new value one edge after that. A gate-pin rise sets the gate flag on the third edge after the pin rises. Register writes and flag clears appear on the edge that samples them, and the output action appears on the same edge as the matching count. The bench runs a behavioural model that steps once per rising edge from the same sampled inputs. It compares the read data and the output pin with that model 1 ns after every falling edge, so any result that arrives one cycle early or late fails at once.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int ADDR_W = 3;
  localparam int PSEL_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } out_act_e;

  // Control register: psel[11:9] init[8] act[7:6] gate_en[5] swr[4] cpe[3] mode[2:0]
  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic              init_lvl;
    out_act_e          act;
    logic              gate_en;
    logic              swr;
    logic              cpe;
    logic [2:0]        mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gct_edge_sync.sv
module gct_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0,
  parameter bit   FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_evt
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
    else        chain_q <= {chain_q[STAGES-1:0], async_in};
  end

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  generate
    if (FALLING) begin : g_fall
      assign edge_evt = chain_q[STAGES] & ~chain_q[STAGES-1];
    end else begin : g_rise
      assign edge_evt = ~chain_q[STAGES] & chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gct_prescaler.sv
module gct_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_evt,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int PC_W = (1 << PSEL_W) - 1;

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] last;

  assign last = (PC_W'(1) << psel) - PC_W'(1);
  assign tick = run && src_evt && (pcnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pcnt_q <= '0;
    else if (!run)       pcnt_q <= '0;
    else if (tick)       pcnt_q <= '0;
    else if (src_evt)    pcnt_q <= pcnt_q + PC_W'(1);
  end
endmodule

// File: rtl/gct_counter.sv
module gct_counter
  import gct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  input  logic [CNT_W-1:0] compare,
  input  out_act_e         act,
  input  logic             init_lvl,
  output logic [CNT_W-1:0] live,
  output logic             hit,
  output logic             tout
);
  logic             loaded_q;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (!loaded_q || live == '0) nxt = preload;
    else                         nxt = live - CNT_W'(1);
  end

  assign hit = run && tick && (nxt == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live     <= '0;
      loaded_q <= 1'b0;
      tout     <= 1'b0;
    end else if (!run) begin
      live     <= '0;
      loaded_q <= 1'b0;
      tout     <= init_lvl;
    end else if (tick) begin
      live     <= nxt;
      loaded_q <= 1'b1;
      if (hit) begin
        unique case (act)
          ACT_TOGGLE: tout <= ~tout;
          ACT_LOW:    tout <= 1'b0;
          ACT_HIGH:   tout <= 1'b1;
          default:    tout <= tout;
        endcase
      end
    end
  end
endmodule

// File: rtl/gated_capture_timer.sv
module gated_capture_timer
  import gct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_clk_in,
  input  logic              gate_n_in,
  output logic              tmr_out
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] pre_q, cmp_q, shadow_q, live_cnt;
  logic             on_q, gate_flag_q, cmp_flag_q;
  logic             run_en, ext_fall, gate_rise, cnt_tick, cmp_hit;
  logic             wr_ctrl, wr_stat, wr_pre, wr_cmp;

  assign run_en  = (ctrl_q.mode == 3'b000) && ctrl_q.cpe && ctrl_q.swr;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_pre  = wr_en && (wr_addr == A_PRE);
  assign wr_cmp  = wr_en && (wr_addr == A_CMP);

  gct_edge_sync #(.STAGES(2), .RST_VAL(1'b0), .FALLING(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in), .edge_evt(ext_fall)
  );

  gct_edge_sync #(.STAGES(2), .RST_VAL(1'b1), .FALLING(1'b0)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .async_in(gate_n_in), .edge_evt(gate_rise)
  );

  gct_prescaler #(.PSEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_en), .src_evt(ext_fall),
    .psel(ctrl_q.psel), .tick(cnt_tick)
  );

  gct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(cnt_tick),
    .preload(pre_q), .compare(cmp_q), .act(ctrl_q.act),
    .init_lvl(ctrl_q.init_lvl), .live(live_cnt), .hit(cmp_hit), .tout(tmr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cmp_q  <= '0;
      on_q   <= 1'b0;
    end else begin
      on_q <= run_en;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_pre)  pre_q  <= wr_data[CNT_W-1:0];
      if (wr_cmp)  cmp_q  <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_flag_q <= 1'b0;
      cmp_flag_q  <= 1'b0;
      shadow_q    <= '0;
    end else begin
      if (!gate_flag_q) shadow_q <= live_cnt;

      if (!run_en)                              gate_flag_q <= 1'b0;
      else if (ctrl_q.gate_en && gate_rise)     gate_flag_q <= 1'b1;
      else if (wr_stat && wr_data[1])           gate_flag_q <= 1'b0;

      if (!run_en)                              cmp_flag_q <= 1'b0;
      else if (cmp_hit)                         cmp_flag_q <= 1'b1;
      else if (wr_stat && wr_data[2])           cmp_flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(ctrl_q);
      A_STAT:  rd_data = DATA_W'({cmp_flag_q, gate_flag_q, on_q});
      A_PRE:   rd_data = DATA_W'(pre_q);
      A_CMP:   rd_data = DATA_W'(cmp_q);
      A_CNT:   rd_data = DATA_W'(shadow_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gct_checker.sv
module gct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             hit,
  input logic             gflag,
  input logic [CNT_W-1:0] shadow,
  input logic [CNT_W-1:0] live,
  input logic             tout,
  input logic             on
);
  // R6: frozen while the gate flag is set
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    gflag |=> $stable(shadow));

  // R6: follows the live counter one cycle late while the flag is clear
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !gflag |=> (shadow == $past(live)));

  // R2: disabled timer idles with count 0 and no gate flag
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (live == '0 && !gflag));

  // R4: the live count moves only on a tick
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(live));

  // R9: the output changes only on a compare hit while running
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> $stable(tout));

  // R3: running bit follows enable one cycle later
  a_r3_on: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (on == $past(en)));
endmodule

bind gated_capture_timer gct_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(run_en), .tick(cnt_tick), .hit(cmp_hit),
  .gflag(gate_flag_q), .shadow(shadow_q), .live(live_cnt), .tout(tmr_out), .on(on_q)
);

// File: tb/gated_capture_timer_tb_top.sv
`timescale 1ns/1ps
module gated_capture_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [15:0] rd_data;
  logic        ext_clk_in = 1'b1;
  logic        gate_n_in = 1'b1;
  logic        tmr_out;

  int checks = 0, errors = 0, cycles = 0;
  bit ext_run = 1'b0;
  bit done = 1'b0;
  string cur_req = "R10";

  gated_capture_timer dut_i (.*);

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_ctrl, m_pre, m_cmp, m_live, m_shadow, m_pcnt;
  bit m_on, m_gflag, m_cflag, m_tout, m_loaded;
  bit e_q[$];   // ext sync chain: [0] newest
  bit g_q[$];   // gate sync chain

  function automatic int model_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return {m_cflag, m_gflag, m_on};
      2: return m_pre;
      3: return m_cmp;
      4: return m_shadow;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pre = 0; m_cmp = 0; m_live = 0; m_shadow = 0; m_pcnt = 0;
      m_on = 0; m_gflag = 0; m_cflag = 0; m_tout = 0; m_loaded = 0;
      e_q = '{0, 0, 0}; g_q = '{1, 1, 1};
    end else begin
      bit en, fall, grise, tick, hit;
      int nxt, n_live, n_pcnt;
      bit n_gflag, n_cflag, n_tout, n_loaded;
      en    = (m_ctrl % 8 == 0) && m_ctrl[3] && m_ctrl[4];
      fall  = e_q[2] && !e_q[1];
      grise = !g_q[2] && g_q[1];
      tick = 0; hit = 0;
      n_live = m_live; n_pcnt = m_pcnt; n_loaded = m_loaded; n_tout = m_tout;
      n_gflag = m_gflag; n_cflag = m_cflag;
      if (!en) begin
        n_live = 0; n_pcnt = 0; n_loaded = 0; n_tout = m_ctrl[8];
        n_gflag = 0; n_cflag = 0;
      end else begin
        if (fall) begin
          if (m_pcnt == (1 << ((m_ctrl >> 9) & 7)) - 1) begin tick = 1; n_pcnt = 0; end
          else n_pcnt = m_pcnt + 1;
        end
        if (tick) begin
          nxt = (!m_loaded || m_live == 0) ? m_pre : m_live - 1;
          n_live = nxt; n_loaded = 1;
          if (nxt == m_cmp) begin
            hit = 1;
            case ((m_ctrl >> 6) & 3)
              1: n_tout = !m_tout;
              2: n_tout = 0;
              3: n_tout = 1;
              default: ;
            endcase
          end
        end
        if (m_ctrl[5] && grise) n_gflag = 1;
        else if (wr_en && wr_addr == 1 && wr_data[1]) n_gflag = 0;
        if (hit) n_cflag = 1;
        else if (wr_en && wr_addr == 1 && wr_data[2]) n_cflag = 0;
      end
      if (!m_gflag) m_shadow = m_live;
      m_on = en;
      m_live = n_live; m_pcnt = n_pcnt; m_loaded = n_loaded; m_tout = n_tout;
      m_gflag = n_gflag; m_cflag = n_cflag;
      if (wr_en && wr_addr == 0) m_ctrl = wr_data & 16'h0FFF;
      if (wr_en && wr_addr == 2) m_pre = wr_data;
      if (wr_en && wr_addr == 3) m_cmp = wr_data;
      e_q.push_front(ext_clk_in); void'(e_q.pop_back());
      g_q.push_front(gate_n_in);  void'(g_q.pop_back());
    end
  end

  // ---------------- checking ----------------
  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check_eq({cur_req, " read data"}, rd_data, model_rd(rd_addr));
      check_eq({cur_req, " tmr_out"}, tmr_out, m_tout);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // free-running external clock: level lasts 3 system cycles
  initial begin
    forever begin
      @(negedge clk);
      repeat (2) @(negedge clk);
      if (ext_run) ext_clk_in = ~ext_clk_in;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gate_pulse();
    @(negedge clk); gate_n_in = 0;
    wait_cyc(3);    gate_n_in = 1;
  endtask

  // ctrl builder: psel, init, act, gate_en, swr, cpe, mode
  function automatic int mk(int psel, int init, int act, int ge, int swr, int cpe, int mode);
    return (psel << 9) | (init << 8) | (act << 6) | (ge << 5) | (swr << 4) | (cpe << 3) | mode;
  endfunction

  initial begin
    int frozen;
    wait_cyc(3);
    rst_n = 1;
    // R10: reset state
    cur_req = "R10";
    for (int a = 0; a < 6; a++) begin
      @(negedge clk); rd_addr = 3'(a); #1;
      check_eq("R10 reset value", rd_data, 0);
    end
    check_eq("R10 reset tmr_out", tmr_out, 0);
    wr(2, 5); wr(3, 3);
    rd_addr = 2; wait_cyc(1); #1; check_eq("R10 preload readback", rd_data, 5);
    ext_run = 1;

    // R1: non-zero mode keeps it idle
    cur_req = "R1";
    wr(0, mk(0, 1, 1, 0, 1, 1, 3'b001));
    rd_addr = 1; wait_cyc(20); #1;
    check_eq("R1 running bit in mode 001", rd_data & 1, 0);
    rd_addr = 4; wait_cyc(1); #1; check_eq("R1 count idle", rd_data, 0);

    // R2: software reset bit clear
    cur_req = "R2";
    wr(0, mk(0, 1, 1, 0, 0, 1, 0));
    wait_cyc(20); #1; check_eq("R2 count idle without swr", rd_data, 0);
    check_eq("R2 init level driven", tmr_out, 1);
    wr(0, mk(0, 0, 1, 0, 1, 0, 0));
    wait_cyc(20); #1; check_eq("R2 count idle without cpe", rd_data, 0);

    // R3/R4/R5/R9: run, toggle on compare, wrap
    cur_req = "R4 R5 R9 toggle";
    wr(0, mk(0, 1, 1, 0, 0, 0, 0));
    wr(0, mk(0, 1, 1, 0, 1, 1, 0));
    rd_addr = 1; wait_cyc(1); #1; check_eq("R3 running bit set", rd_data & 1, 1);
    rd_addr = 4; wait_cyc(90);
    rd_addr = 1; wait_cyc(2); #1; check_eq("R9 compare flag set", (rd_data >> 2) & 1, 1);
    cur_req = "R8 compare clear";
    wr(1, 0); wr(1, 4);
    wait_cyc(1); #1; check_eq("R8 compare flag cleared", (rd_data >> 2) & 1, 0);

    // R6/R7/R8: gate freeze
    cur_req = "R7 gate freeze";
    wr(0, mk(0, 0, 3, 1, 0, 1, 0));
    wr(0, mk(0, 0, 3, 1, 1, 1, 0));
    rd_addr = 4; wait_cyc(25);
    gate_pulse();
    wait_cyc(4); #1; frozen = rd_data;
    wait_cyc(30); #1; check_eq("R7 count held while flagged", rd_data, frozen);
    rd_addr = 1; #1; check_eq("R7 gate flag set", (rd_data >> 1) & 1, 1);
    cur_req = "R8 gate clear";
    wr(1, 1); wait_cyc(1); #1; check_eq("R8 write zero keeps flag", (rd_data >> 1) & 1, 1);
    wr(1, 2); wait_cyc(1); #1; check_eq("R8 gate flag cleared", (rd_data >> 1) & 1, 0);
    cur_req = "R6 shadow resumes";
    rd_addr = 4; wait_cyc(30);

    // R7: gate enable clear, gate pin ignored; prescale by 4; drive low
    cur_req = "R7 gate disabled, R5 prescale";
    wr(0, mk(2, 1, 2, 0, 0, 1, 0));
    wr(0, mk(2, 1, 2, 0, 1, 1, 0));
    wait_cyc(30);
    gate_pulse();
    rd_addr = 1; wait_cyc(6); #1; check_eq("R7 no flag with gate disabled", (rd_data >> 1) & 1, 0);
    rd_addr = 4; wait_cyc(200);
    cur_req = "R9 hold action";
    wr(0, mk(1, 1, 0, 0, 0, 1, 0));
    wr(0, mk(1, 1, 0, 0, 1, 1, 0));
    wait_cyc(150); #1; check_eq("R9 hold keeps init level", tmr_out, 1);
    cur_req = "R3 disable";
    wr(0, 0);
    rd_addr = 1; wait_cyc(2); #1; check_eq("R3 running bit cleared", rd_data & 1, 0);
    wait_cyc(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule